// File: doc/BRIEF.md
# Prescaled Up/Down Interval Timer

A 16-bit general-purpose timer set up through a small register file on a single-cycle write / registered-read port. Software picks the count direction, a periodic or free-running mode, and a tick rate from a prescaler. Then it sets the enable bit. In periodic mode the count begins at a programmable reload value and returns to it each time it runs past its end. In free-running mode the count begins at 0x0000 when counting up or at 0xFFFF when counting down, and it wraps across the full 16-bit range.

Each time the count runs past its end, a sticky timeout flag is set. An external capture strobe copies the present count into a capture register and sets a sticky capture flag. Both flags are cleared by writing ones to a clear register, and they drive a combined interrupt line.

Register offsets on `addr`:

| Offset | Register | Access |
|---|---|---|
| 0 | control | read/write |
| 1 | reload value | read/write |
| 2 | current count | read only |
| 3 | flag clear | write ones to clear, reads 0 |
| 4 | flags | read only |
| 5 | captured count | read only |

Any other offset reads 0.

Top module: `gpt_timer`

## Requirements
- R1: After reset the block is in this state:
  - control reads 0x0012: disabled, periodic, counting down, prescale code 2.
  - The reload value, current count, flags and captured count read 0.
  - `irq` is low.
- R2: While control bit 0 (enable) is 0, the current count is 0 and the prescaler is held at its start. Clearing enable zeroes the count at the next clock edge.
- R3: In the first clock after enable is set, the count is loaded with its start value:
  - periodic mode (control bit 1 = 1): the reload value;
  - free-running mode, counting up (control bit 2 = 1): 0x0000;
  - free-running mode, counting down (control bit 2 = 0): 0xFFFF.
- R4: Control bits [4:3] set the tick divide. Code 1 divides by 16, code 2 by 64 and code 3 by 256. Code 0 divides by 1 when control bit 15 is 1, and by 4 when it is 0. With the timer running, the count changes exactly once per divide period of clocks.
- R5: On each tick the count goes up by one when control bit 2 is 1, and down by one when it is 0.
- R6: In periodic mode, a tick at 0x0000 when counting down, or at 0xFFFF when counting up, reloads the reload value and sets the timeout flag (flags bit 0).
- R7: In free-running mode, a tick at the end of the range wraps the count to 0x0000 when counting up or to 0xFFFF when counting down, and sets the timeout flag.
- R8: The flags are sticky. Writing the clear register clears the timeout flag where data bit 0 is 1 and the capture flag where data bit 1 is 1. Zero bits have no effect. If a flag is set and cleared in the same cycle, it stays set.
- R9: A high `capture_i` in a cycle stores the count held in that cycle into the captured-count register and sets the capture flag (flags bit 1).
- R10: `irq` is the OR of the two flags. `irq_timeout` and `irq_capture` show each flag on its own.
- R11: `rdata` shows, one clock after `addr` is presented, the addressed register as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | register write strobe |
| addr | input | 3 | register offset for the write and the read |
| wdata | input | 16 | write data |
| rdata | output | 16 | registered read data |
| capture_i | input | 1 | capture strobe |
| irq_timeout | output | 1 | timeout flag |
| irq_capture | output | 1 | capture flag |
| irq | output | 1 | combined interrupt |

## Verification
The bound checker checks the following on every cycle:
- a disabled timer has a zero count;
- the count holds still between ticks;
- every tick moves the count by exactly one in the programmed direction;
- a down-count past zero raises the timeout flag;
- the flags stay set until a matching clear;
- a capture strobe always sets its flag.

Other behaviour can only be shown by the bench's scenarios. This covers the exact tick period for each prescale code, the start values for each mode and direction, the reload and wrap values seen at the port, a set and a clear in the same cycle, and the full 65536-tick free-running wrap. For these, the bench holds the read port on a register and compares what it reads against a behavioural model on every clock.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  // Register offsets on the access port
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_LOAD  = 3'd1;
  localparam logic [2:0] A_COUNT = 3'd2;
  localparam logic [2:0] A_CLEAR = 3'd3;
  localparam logic [2:0] A_FLAGS = 3'd4;
  localparam logic [2:0] A_CAPT  = 3'd5;

  // Control bit positions
  localparam int CB_EN       = 0;
  localparam int CB_PERIODIC = 1;
  localparam int CB_UP       = 2;
  localparam int CB_PRE_LO   = 3;
  localparam int CB_FAST     = 15;

  // Flag indices (also the bit positions in the clear and flags registers)
  localparam int F_TMO = 0;
  localparam int F_CAP = 1;
  localparam int NFLAGS = 2;

  localparam logic [15:0] CTRL_MASK  = 16'h801F;
  localparam logic [15:0] CTRL_RESET = 16'h0012;

endpackage

// File: rtl/gpt_prescale.sv
module gpt_prescale #(
  parameter int PW = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] code,
  input  logic       fast,
  output logic       tick
);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] lim;

  // Terminal count: divide - 1 for each prescale code (R4)
  always_comb begin
    case (code)
      2'd0:    lim = fast ? PW'(0) : PW'(3);
      2'd1:    lim = PW'(15);
      2'd2:    lim = PW'(63);
      default: lim = PW'(255);
    endcase
  end

  // >= so that a smaller code chosen mid-period still ends the period
  assign tick = run && (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/gpt_count.sv
module gpt_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         periodic,
  input  logic         up,
  input  logic [W-1:0] load,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         run,
  output logic         wrap
);

  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] count_q;
  logic         started_q;
  logic [W-1:0] start_val;
  logic         at_end;

  // Start value (R3)
  always_comb begin
    if (periodic)
      start_val = load;
    else if (up)
      start_val = '0;
    else
      start_val = ONES;
  end

  assign at_end = up ? (count_q == ONES) : (count_q == '0);
  assign run    = en && started_q;
  assign wrap   = run && tick && at_end;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      // R2: disabled timer holds a zero count
      count_q   <= '0;
      started_q <= 1'b0;
    end else if (!started_q) begin
      count_q   <= start_val;
      started_q <= 1'b1;
    end else if (tick) begin
      if (at_end)
        count_q <= start_val;          // R6 reload / R7 wrap
      else if (up)
        count_q <= count_q + 1'b1;     // R5
      else
        count_q <= count_q - 1'b1;
    end
  end

  assign count = count_q;

endmodule

// File: rtl/gpt_flags.sv
module gpt_flags #(
  parameter int W = 16,
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic         cap_load,
  input  logic [W-1:0] cap_val,
  output logic [N-1:0] flags,
  output logic [W-1:0] cap_q
);

  // One sticky flag per source; a set beats a clear in the same cycle (R8)
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk) begin
      if (rst)
        f_q <= 1'b0;
      else
        f_q <= set[i] | (f_q & ~clr[i]);
    end
    assign flags[i] = f_q;
  end

  // Captured count (R9)
  always_ff @(posedge clk) begin
    if (rst)
      cap_q <= '0;
    else if (cap_load)
      cap_q <= cap_val;
  end

endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
  import gpt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              capture_i,
  output logic              irq_timeout,
  output logic              irq_capture,
  output logic              irq
);

  localparam logic [DATA_W-1:0] C_MASK  = DATA_W'(CTRL_MASK);
  localparam logic [DATA_W-1:0] C_RESET = DATA_W'(CTRL_RESET);

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] count_w;
  logic [DATA_W-1:0] capt_w;
  logic [NFLAGS-1:0] flags_w;
  logic [NFLAGS-1:0] set_w;
  logic [NFLAGS-1:0] clr_w;
  logic              tick_w;
  logic              run_w;
  logic              wrap_w;
  logic              wr_ctrl, wr_load, wr_clear;

  assign wr_ctrl  = wr_en && (addr == ADDR_W'(A_CTRL));
  assign wr_load  = wr_en && (addr == ADDR_W'(A_LOAD));
  assign wr_clear = wr_en && (addr == ADDR_W'(A_CLEAR));

  // Control and reload registers (R1)
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= C_RESET;
      load_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata & C_MASK;
      if (wr_load) load_q <= wdata;
    end
  end

  gpt_prescale #(.PW(PRE_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (run_w),
    .code (ctrl_q[CB_PRE_LO+1:CB_PRE_LO]),
    .fast (ctrl_q[CB_FAST]),
    .tick (tick_w)
  );

  gpt_count #(.W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .en       (ctrl_q[CB_EN]),
    .periodic (ctrl_q[CB_PERIODIC]),
    .up       (ctrl_q[CB_UP]),
    .load     (load_q),
    .tick     (tick_w),
    .count    (count_w),
    .run      (run_w),
    .wrap     (wrap_w)
  );

  assign set_w[F_TMO] = wrap_w;
  assign set_w[F_CAP] = capture_i;
  assign clr_w[F_TMO] = wr_clear && wdata[F_TMO];
  assign clr_w[F_CAP] = wr_clear && wdata[F_CAP];

  gpt_flags #(.W(DATA_W), .N(NFLAGS)) u_flg (
    .clk      (clk),
    .rst      (rst),
    .set      (set_w),
    .clr      (clr_w),
    .cap_load (capture_i),
    .cap_val  (count_w),
    .flags    (flags_w),
    .cap_q    (capt_w)
  );

  // Registered read port (R11)
  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else begin
      case (addr)
        ADDR_W'(A_CTRL):  rdata <= ctrl_q;
        ADDR_W'(A_LOAD):  rdata <= load_q;
        ADDR_W'(A_COUNT): rdata <= count_w;
        ADDR_W'(A_FLAGS): rdata <= DATA_W'(flags_w);
        ADDR_W'(A_CAPT):  rdata <= capt_w;
        default:          rdata <= '0;
      endcase
    end
  end

  // R10
  assign irq_timeout = flags_w[F_TMO];
  assign irq_capture = flags_w[F_CAP];
  assign irq         = |flags_w;

endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              capture_i,
  input logic              ctrl_en,
  input logic              up,
  input logic              run,
  input logic              tick,
  input logic [DATA_W-1:0] count,
  input logic              tmo_q,
  input logic              cap_q
);

  localparam logic [DATA_W-1:0] ONES = '1;

  logic ctrl_wr;
  logic tmo_clr;
  assign ctrl_wr = wr_en && (addr == ADDR_W'(gpt_pkg::A_CTRL));
  assign tmo_clr = wr_en && (addr == ADDR_W'(gpt_pkg::A_CLEAR)) && wdata[0];

  p_disabled_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> (count == '0));

  p_hold_between_ticks_r4: assert property (@(posedge clk) disable iff (rst)
    (run && !tick && !ctrl_wr) |=> $stable(count));

  p_up_step_r5: assert property (@(posedge clk) disable iff (rst)
    (run && tick && up && (count != ONES) && !ctrl_wr)
      |=> (count == DATA_W'($past(count) + 1'b1)));

  p_down_step_r5: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !up && (count != '0) && !ctrl_wr)
      |=> (count == DATA_W'($past(count) - 1'b1)));

  p_end_sets_timeout_r6: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !up && (count == '0)) |=> tmo_q);

  p_timeout_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (tmo_q && !tmo_clr) |=> tmo_q);

  p_capture_sets_flag_r9: assert property (@(posedge clk) disable iff (rst)
    capture_i |=> cap_q);

endmodule

bind gpt_timer gpt_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .addr      (addr),
  .wdata     (wdata),
  .capture_i (capture_i),
  .ctrl_en   (ctrl_q[0]),
  .up        (ctrl_q[2]),
  .run       (run_w),
  .tick      (tick_w),
  .count     (count_w),
  .tmo_q     (flags_w[0]),
  .cap_q     (flags_w[1])
);

// File: tb/gpt_timer_bench.sv
module gpt_timer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        capture_i = 1'b0;
  logic        irq_timeout, irq_capture, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;   // 50 MHz

  gpt_timer u_gpt_timer (
    .clk (clk), .rst (rst), .wr_en (wr_en), .addr (addr), .wdata (wdata),
    .rdata (rdata), .capture_i (capture_i), .irq_timeout (irq_timeout),
    .irq_capture (irq_capture), .irq (irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_ctrl, m_load, m_cnt, m_capv, m_rdata;
  logic        m_started, m_tmo, m_cap;
  int          m_pcnt;

  function automatic int mdiv(input logic [15:0] c);
    int code;
    code = int'(c[4:3]);
    if (code == 0) return c[15] ? 1 : 4;
    return 4 ** (code + 1);
  endfunction

  always @(posedge clk) begin
    logic tick_m, tset;
    if (rst) begin
      m_ctrl = 16'h0012; m_load = 0; m_cnt = 0; m_capv = 0; m_rdata = 0;
      m_started = 0; m_tmo = 0; m_cap = 0; m_pcnt = 0;
    end else begin
      case (addr)
        3'd0: m_rdata = m_ctrl;
        3'd1: m_rdata = m_load;
        3'd2: m_rdata = m_cnt;
        3'd4: m_rdata = {14'h0, m_cap, m_tmo};
        3'd5: m_rdata = m_capv;
        default: m_rdata = 0;
      endcase
      if (capture_i) m_capv = m_cnt;
      tset = 0;
      tick_m = m_ctrl[0] && m_started && (m_pcnt >= mdiv(m_ctrl) - 1);
      if (!m_ctrl[0]) begin
        m_cnt = 0; m_started = 0; m_pcnt = 0;
      end else if (!m_started) begin
        m_cnt = m_ctrl[1] ? m_load : (m_ctrl[2] ? 16'h0000 : 16'hFFFF);
        m_started = 1; m_pcnt = 0;
      end else begin
        m_pcnt = tick_m ? 0 : m_pcnt + 1;
        if (tick_m) begin
          if (m_ctrl[2] && m_cnt == 16'hFFFF) begin
            tset = 1; m_cnt = m_ctrl[1] ? m_load : 16'h0000;
          end else if (!m_ctrl[2] && m_cnt == 16'h0000) begin
            tset = 1; m_cnt = m_ctrl[1] ? m_load : 16'hFFFF;
          end else if (m_ctrl[2]) m_cnt = m_cnt + 16'd1;
          else m_cnt = m_cnt - 16'd1;
        end
      end
      m_tmo = tset | (m_tmo & !(wr_en && addr == 3'd3 && wdata[0]));
      m_cap = capture_i | (m_cap & !(wr_en && addr == 3'd3 && wdata[1]));
      if (wr_en && addr == 3'd0) m_ctrl = wdata & 16'h801F;
      if (wr_en && addr == 3'd1) m_load = wdata;
    end
  end

  // Cycle-by-cycle comparison against the model (R10, R11)
  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (rdata !== m_rdata) begin
        n_bad++;
        $display("FAIL R11 rdata addr=%0d actual=%h expected=%h", addr, rdata, m_rdata);
      end
      n_chk++;
      if ({irq, irq_capture, irq_timeout} !== {m_tmo | m_cap, m_cap, m_tmo}) begin
        n_bad++;
        $display("FAIL R10 irq actual=%b expected=%b", {irq, irq_capture, irq_timeout},
                 {m_tmo | m_cap, m_cap, m_tmo});
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = 16'h0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  // Interval in clocks between the 2nd and 3rd change of the count
  task automatic measure(output int iv, output logic [15:0] v1, output logic [15:0] v2);
    logic [15:0] prev;
    int changes = 0;
    int cyc = 0;
    @(negedge clk); addr = 3'd2;
    @(negedge clk); prev = rdata;
    iv = 0; v1 = 0; v2 = 0;
    while (changes < 3) begin
      @(negedge clk); cyc++;
      if (rdata !== prev) begin
        changes++;
        if (changes == 2) begin cyc = 0; v1 = rdata; end
        if (changes == 3) begin iv = cyc; v2 = rdata; end
        prev = rdata;
      end
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    logic [15:0] d, v1, v2, prev;
    int iv;
    int divs[4] = '{1, 4, 16, 64};
    logic [15:0] ctl[4] = '{16'h8003, 16'h0003, 16'h000B, 16'h0013};

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd0, d); check("R1 ctrl", d, 16'h0012);
    rd(3'd1, d); check("R1 load", d, 16'h0000);
    rd(3'd2, d); check("R1 count", d, 16'h0000);
    rd(3'd4, d); check("R1 flags", d, 16'h0000);
    check("R1 irq", {15'h0, irq}, 16'h0);

    // R3 periodic start, slow prescale so no tick interferes
    wr(3'd1, 16'h1234);
    wr(3'd0, 16'h001B);
    rd(3'd2, d); check("R3 periodic start", d, 16'h1234);

    // R2 disable clears the count
    wr(3'd0, 16'h001A);
    rd(3'd2, d); check("R2 disabled count", d, 16'h0000);

    // R3 free-running down start
    wr(3'd0, 16'h0019);
    rd(3'd2, d); check("R3 free down start", d, 16'hFFFF);
    wr(3'd0, 16'h0018);

    // R9 capture of a held count
    wr(3'd0, 16'h001B);
    @(negedge clk); capture_i = 1'b1;
    @(negedge clk); capture_i = 1'b0;
    rd(3'd5, d); check("R9 captured count", d, 16'h1234);
    rd(3'd4, d); check("R9 capture flag", d, 16'h0002);
    check("R10 irq from capture", {15'h0, irq}, 16'h1);

    // R8 write-one-to-clear
    wr(3'd3, 16'h0000);
    rd(3'd4, d); check("R8 zero write no effect", d, 16'h0002);
    wr(3'd3, 16'h0002);
    rd(3'd4, d); check("R8 clear capture", d, 16'h0000);
    @(negedge clk); wr_en = 1'b1; addr = 3'd3; wdata = 16'h0002; capture_i = 1'b1;
    @(negedge clk); wr_en = 1'b0; capture_i = 1'b0;
    rd(3'd4, d); check("R8 set wins over clear", d, 16'h0002);
    wr(3'd3, 16'h0003);
    wr(3'd0, 16'h001A);

    // R4 / R5 prescale periods and step direction
    wr(3'd1, 16'd1000);
    for (int i = 0; i < 4; i++) begin
      wr(3'd0, 16'h0002);
      wr(3'd0, ctl[i]);
      measure(iv, v1, v2);
      check("R4 tick period", 16'(iv), 16'(divs[i]));
      check("R5 down step", v2, v1 - 16'd1);
    end
    wr(3'd0, 16'h0002);
    wr(3'd0, 16'h0007);   // periodic, up, divide by 4
    measure(iv, v1, v2);
    check("R4 tick period up", 16'(iv), 16'd4);
    check("R5 up step", v2, v1 + 16'd1);

    // R6 periodic reload with timeout
    wr(3'd0, 16'h0002);
    wr(3'd3, 16'h0003);
    wr(3'd1, 16'h0002);
    wr(3'd0, 16'h8003);
    @(negedge clk); addr = 3'd2;
    @(negedge clk); prev = rdata;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check("R6 periodic sequence", rdata, (prev == 16'h0) ? 16'h0002 : prev - 16'd1);
      prev = rdata;
    end
    rd(3'd4, d); check("R6 timeout flag", d & 16'h1, 16'h0001);

    // R7 free-running up wrap across the full range
    wr(3'd0, 16'h0002);
    wr(3'd3, 16'h0003);
    rd(3'd4, d); check("R8 timeout cleared", d, 16'h0000);
    wr(3'd0, 16'h8005);
    @(negedge clk); addr = 3'd2;
    while (rdata !== 16'hFFFF) @(negedge clk);
    @(negedge clk);
    check("R7 wrap to zero", rdata, 16'h0000);
    rd(3'd4, d); check("R7 timeout flag", d & 16'h1, 16'h0001);
    check("R10 irq from timeout", {15'h0, irq}, 16'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule